// File: doc/BRIEF.md
# Timestamped Cluster RLE Expander

This block turns a stream of run-length-compressed capture clusters back into an uninterrupted stream of samples. Each incoming cluster carries a 16-bit timestamp, a count of valid events (at most seven) and the event words themselves. The block keeps the timestamp it expects the next cluster to have. When a cluster arrives with a later timestamp, the events in between were never stored because the inputs did not change. The block fills that hole by replaying the last sample it emitted.

The distance between the cluster timestamp and the expected one is taken modulo 2^16, so timestamps may wrap. Each missing event stands for one, two or four output samples, depending on the samples-per-event setting. After the replay, the block emits the cluster's own events in index order. It then sets the expected timestamp to the cluster timestamp plus seven, whatever the event count was. A cluster flagged as the first of a readout seeds the expected timestamp from itself and clears the held sample. The output uses a valid/ready handshake, and the held sample is visible on a port.

Top module: `cluster_rle_expander`

## Requirements
- R1: A cluster accepted with `cl_first`=1 produces no replay samples and clears the held sample to 0 before its events are emitted.
- R2: For a cluster without `cl_first`, the number of missing events is (`cl_ts` − expected timestamp) mod 65536, and this still holds when the timestamp wraps past 0xFFFF.
- R3: After any cluster is accepted, the expected timestamp becomes `cl_ts`+7 mod 65536, for every event count including 0. A following cluster with exactly that timestamp produces no replay.
- R4: Each missing event is emitted as copies of `held_sample`. The number of copies is set by `cl_spe`: code 0 gives 1, code 1 gives 2, and codes 2 and 3 give 4. All replay samples come out before the cluster's own events.
- R5: The cluster's events are emitted in the order 0 to `cl_count`−1, where event i sits in `cl_events[16*i +: 16]`. Only the first `cl_count` events are emitted, so a count below 7 describes a partial cluster.
- R6: A cluster with `cl_count`=0 emits its replay samples only and leaves `held_sample` unchanged.
- R7: `held_sample` takes the value of each event sample as it is transferred, so after a cluster it equals that cluster's last event.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays at 1 and `out_sample` stays unchanged. Under any backpressure pattern no sample is lost or repeated.
- R9: `cl_ready` is 1 only while no output sample is pending (`out_valid`=0), so a cluster is accepted only when the previous one is finished.
- R10: After reset, `out_valid`=0, `cl_ready`=1 and `held_sample`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl_valid | input | 1 | Cluster offered |
| cl_ready | output | 1 | Cluster accepted this cycle when high together with cl_valid |
| cl_first | input | 1 | Cluster is the first of a readout |
| cl_ts | input | 16 | Cluster timestamp |
| cl_count | input | 3 | Valid events in the cluster (0..7) |
| cl_spe | input | 2 | Samples-per-event code (0:1, 1:2, 2 and 3:4) |
| cl_events | input | 112 | Event words, event i at bits 16*i+15..16*i |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer takes the output sample |
| out_sample | output | 16 | Output sample |
| held_sample | output | 16 | Last event sample emitted (replay value) |

## Verification
A wrong expected timestamp shows up as a wrong number of replay samples on the very next cluster. An adjacent cluster then gains or loses replay copies, and the sample stream drifts against the model from that point on. A wrong held value shows up at once as wrong replay words and as a mismatch on `held_sample` when the block goes idle. A wrong event index or an error in the stall logic shows up within the same cluster as a reordered, dropped or duplicated word. The bench therefore compares every transferred word against a model queue while it applies random backpressure.

// File: rtl/cre_pkg.sv
package cre_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GAP  = 2'd1,
        PH_EVT  = 2'd2
    } phase_e;

    localparam int SPE_CODE_W = 2;
    localparam int SPE_MAX_SHIFT = 2;
endpackage

// File: rtl/cre_spe_decode.sv
module cre_spe_decode
    import cre_pkg::*;
(
    input  logic [SPE_CODE_W-1:0] code,
    output logic [1:0]            shift
);
    always_comb begin
        case (code)
            2'd0:    shift = 2'd0;
            2'd1:    shift = 2'd1;
            default: shift = 2'(SPE_MAX_SHIFT);
        endcase
    end
endmodule

// File: rtl/cre_gap_calc.sv
module cre_gap_calc #(
    parameter int TS_W  = 16,
    parameter int REP_W = TS_W + 2
) (
    input  logic [TS_W-1:0]  ts,
    input  logic [TS_W-1:0]  exp_ts,
    input  logic             first,
    input  logic [1:0]       shift,
    output logic [REP_W-1:0] replay
);
    logic [TS_W-1:0]  gap;
    logic [REP_W-1:0] gap_wide;

    always_comb begin
        gap      = first ? '0 : (ts - exp_ts);
        gap_wide = {{(REP_W-TS_W){1'b0}}, gap};
        replay   = gap_wide << shift;
    end
endmodule

// File: rtl/cre_event_pick.sv
module cre_event_pick #(
    parameter int SAMPLE_W   = 16,
    parameter int EVENTS_MAX = 7,
    parameter int IDX_W      = 3
) (
    input  logic [EVENTS_MAX*SAMPLE_W-1:0] events,
    input  logic [IDX_W-1:0]               idx,
    output logic [SAMPLE_W-1:0]            sample
);
    logic [SAMPLE_W-1:0] lane [EVENTS_MAX];

    for (genvar g = 0; g < EVENTS_MAX; g++) begin : g_lane
        assign lane[g] = events[g*SAMPLE_W +: SAMPLE_W];
    end

    always_comb begin
        sample = '0;
        for (int i = 0; i < EVENTS_MAX; i++) begin
            if (idx == IDX_W'(i)) sample = lane[i];
        end
    end
endmodule

// File: rtl/cluster_rle_expander.sv
module cluster_rle_expander
    import cre_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int TS_W       = 16,
    parameter int EVENTS_MAX = 7,
    parameter int CNT_W      = $clog2(EVENTS_MAX + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cl_valid,
    output logic                           cl_ready,
    input  logic                           cl_first,
    input  logic [TS_W-1:0]                cl_ts,
    input  logic [CNT_W-1:0]               cl_count,
    input  logic [SPE_CODE_W-1:0]          cl_spe,
    input  logic [EVENTS_MAX*SAMPLE_W-1:0] cl_events,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [SAMPLE_W-1:0]            out_sample,
    output logic [SAMPLE_W-1:0]            held_sample
);
    localparam int IDX_W = CNT_W;
    localparam int REP_W = TS_W + SPE_MAX_SHIFT;
    localparam int EVB_W = EVENTS_MAX * SAMPLE_W;

    typedef struct packed {
        phase_e              phase;
        logic [TS_W-1:0]     exp_ts;
        logic [SAMPLE_W-1:0] held;
        logic [REP_W-1:0]    rep;
        logic [IDX_W-1:0]    idx;
        logic [CNT_W-1:0]    cnt;
        logic [EVB_W-1:0]    events;
    } state_t;

    state_t st_q, st_d;

    logic [1:0]          spe_shift;
    logic [REP_W-1:0]    replay_len;
    logic [SAMPLE_W-1:0] picked;
    logic [CNT_W-1:0]    cnt_in;
    logic [IDX_W-1:0]    idx_inc;
    logic                accept;
    logic                replay_active;

    cre_spe_decode u_spe (
        .code  (cl_spe),
        .shift (spe_shift)
    );

    cre_gap_calc #(
        .TS_W  (TS_W),
        .REP_W (REP_W)
    ) u_gap (
        .ts     (cl_ts),
        .exp_ts (st_q.exp_ts),
        .first  (cl_first),
        .shift  (spe_shift),
        .replay (replay_len)
    );

    cre_event_pick #(
        .SAMPLE_W   (SAMPLE_W),
        .EVENTS_MAX (EVENTS_MAX),
        .IDX_W      (IDX_W)
    ) u_pick (
        .events (st_q.events),
        .idx    (st_q.idx),
        .sample (picked)
    );

    always_comb begin
        st_d    = st_q;
        cnt_in  = (cl_count > CNT_W'(EVENTS_MAX)) ? CNT_W'(EVENTS_MAX) : cl_count;
        idx_inc = st_q.idx + IDX_W'(1);
        accept  = cl_valid && (st_q.phase == PH_IDLE);

        case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    st_d.exp_ts = cl_ts + TS_W'(EVENTS_MAX);
                    if (cl_first) st_d.held = '0;
                    st_d.rep    = replay_len;
                    st_d.cnt    = cnt_in;
                    st_d.idx    = '0;
                    st_d.events = cl_events;
                    if (replay_len != '0)       st_d.phase = PH_GAP;
                    else if (cnt_in != '0)      st_d.phase = PH_EVT;
                    else                        st_d.phase = PH_IDLE;
                end
            end
            PH_GAP: begin
                if (out_ready) begin
                    st_d.rep = st_q.rep - REP_W'(1);
                    if (st_q.rep == REP_W'(1)) begin
                        st_d.phase = (st_q.cnt != '0) ? PH_EVT : PH_IDLE;
                    end
                end
            end
            PH_EVT: begin
                if (out_ready) begin
                    st_d.held = picked;
                    st_d.idx  = idx_inc;
                    if (idx_inc == st_q.cnt) st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.exp_ts <= '0;
            st_q.held   <= '0;
            st_q.rep    <= '0;
            st_q.idx    <= '0;
            st_q.cnt    <= '0;
            st_q.events <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign replay_active = (st_q.phase == PH_GAP);
    assign cl_ready      = (st_q.phase == PH_IDLE);
    assign out_valid     = (st_q.phase != PH_IDLE);
    assign out_sample    = replay_active ? st_q.held : picked;
    assign held_sample   = st_q.held;
endmodule

// File: rtl/cluster_rle_expander_chk.sv
module cluster_rle_expander_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cl_valid,
    input logic                cl_ready,
    input logic                cl_first,
    input logic                out_valid,
    input logic                out_ready,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic [SAMPLE_W-1:0] held_sample,
    input logic                replay_active
);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cl_ready && out_valid));

    // R4
    replay_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_active |-> (out_valid && out_sample == held_sample));

    // R7
    held_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(held_sample) |->
            ($past(out_valid && out_ready) || $past(cl_valid && cl_ready && cl_first)));
endmodule

bind cluster_rle_expander cluster_rle_expander_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cl_valid      (cl_valid),
    .cl_ready      (cl_ready),
    .cl_first      (cl_first),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_sample    (out_sample),
    .held_sample   (held_sample),
    .replay_active (replay_active)
);

// File: tb/cluster_rle_expander_test.sv
module cluster_rle_expander_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cl_valid = 1'b0;
    logic         cl_ready;
    logic         cl_first = 1'b0;
    logic [15:0]  cl_ts = '0;
    logic [2:0]   cl_count = '0;
    logic [1:0]   cl_spe = '0;
    logic [111:0] cl_events = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [15:0]  out_sample;
    logic [15:0]  held_sample;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit consumer_on = 0;

    logic [15:0] exp_q[$];
    int          kind_q[$];
    logic [15:0] m_exp = '0;
    logic [15:0] m_held = '0;

    cluster_rle_expander uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cl_valid    (cl_valid),
        .cl_ready    (cl_ready),
        .cl_first    (cl_first),
        .cl_ts       (cl_ts),
        .cl_count    (cl_count),
        .cl_spe      (cl_spe),
        .cl_events   (cl_events),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_sample  (out_sample),
        .held_sample (held_sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int spe_factor(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    function automatic int gap_events(input bit first, input logic [15:0] ts,
                                      input logic [15:0] expv);
        logic [15:0] d;
        d = ts - expv;
        return first ? 0 : int'(d);
    endfunction

    task automatic model_push(input bit first, input logic [15:0] ts,
                              input logic [2:0] cnt, input logic [1:0] spe,
                              input logic [111:0] ev);
        int n;
        if (first) m_held = '0;
        n = gap_events(first, ts, m_exp) * spe_factor(spe);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(m_held);
            kind_q.push_back(0);
        end
        for (int i = 0; i < int'(cnt); i++) begin
            exp_q.push_back(ev[16*i +: 16]);
            kind_q.push_back(1);
        end
        if (cnt != 0) m_held = ev[16*(int'(cnt)-1) +: 16];
        m_exp = ts + 16'd7;
    endtask

    task automatic send(input bit first, input logic [15:0] ts,
                        input logic [2:0] cnt, input logic [1:0] spe,
                        input logic [111:0] ev);
        @(negedge clk);
        cl_first  = first;
        cl_ts     = ts;
        cl_count  = cnt;
        cl_spe    = spe;
        cl_events = ev;
        cl_valid  = 1'b1;
        #1;
        while (!cl_ready) begin
            @(negedge clk);
            #1;
        end
        model_push(first, ts, cnt, spe, ev);
        @(negedge clk);
        cl_valid = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        @(negedge clk);
        #2;
        while (!(cl_ready && exp_q.size() == 0)) begin
            @(negedge clk);
            #2;
        end
        checks++;
        if (held_sample !== m_held) begin
            errors++;
            $display("FAIL %s held_sample actual=%h expected=%h", tag, held_sample, m_held);
        end
    endtask

    function automatic logic [111:0] rand_events();
        logic [111:0] v;
        for (int i = 0; i < 7; i++) v[16*i +: 16] = 16'($urandom);
        return v;
    endfunction

    function automatic logic [111:0] seq_events(input logic [15:0] base);
        logic [111:0] v;
        for (int i = 0; i < 7; i++) v[16*i +: 16] = base + 16'(i);
        return v;
    endfunction

    // consumer: random backpressure, word-by-word comparison
    logic [15:0] stall_val;
    bit          stall_pend = 0;
    always @(negedge clk) begin
        if (consumer_on) begin
            out_ready = ($urandom % 4) != 0;
            #1;
            if (stall_pend && out_valid === 1'b1) begin
                checks++;
                if (out_sample !== stall_val) begin
                    errors++;
                    $display("FAIL R8 stalled word changed actual=%h expected=%h", out_sample, stall_val);
                end
            end else if (stall_pend) begin
                checks++;
                errors++;
                $display("FAIL R8 out_valid dropped under stall actual=0 expected=1");
            end
            stall_pend = 0;
            if (out_valid === 1'b1) begin
                checks++;
                if (cl_ready !== 1'b0) begin
                    errors++;
                    $display("FAIL R9 cl_ready while busy actual=%b expected=0", cl_ready);
                end
            end
            if (out_valid === 1'b1 && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R5 extra output word actual=%h expected=none", out_sample);
                end else begin
                    logic [15:0] e;
                    int k;
                    e = exp_q.pop_front();
                    k = kind_q.pop_front();
                    if (out_sample !== e) begin
                        errors++;
                        if (k == 0)
                            $display("FAIL R4 replay word actual=%h expected=%h", out_sample, e);
                        else
                            $display("FAIL R5 event word actual=%h expected=%h", out_sample, e);
                    end
                end
            end else if (out_valid === 1'b1) begin
                stall_pend = 1;
                stall_val  = out_sample;
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc >= WATCHDOG && !done) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d cycles expected=<%0d", cyc, WATCHDOG);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] seed_tmp;
        seed_tmp = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        checks++;
        if (out_valid !== 1'b0 || cl_ready !== 1'b1 || held_sample !== 16'h0) begin
            errors++;
            $display("FAIL R10 reset state actual=%b%b/%h expected=01/0000", out_valid, cl_ready, held_sample);
        end
        rst_n = 1'b1;
        consumer_on = 1;

        // R1: first cluster, no replay, full cluster
        send(1, 16'h0100, 3'd7, 2'd0, seq_events(16'hA000));
        wait_idle("R1 R7");
        // R3: adjacent cluster, no replay
        send(0, 16'h0107, 3'd7, 2'd0, seq_events(16'hB000));
        wait_idle("R3");
        // R4: gap of 3 events, factor 2
        send(0, 16'h0111, 3'd2, 2'd1, seq_events(16'hC000));
        wait_idle("R4 x2");
        // R4: gap of 2 events, factor 4 (code 2) and code 3
        send(0, 16'h011A, 3'd1, 2'd2, seq_events(16'hD000));
        wait_idle("R4 x4");
        send(0, 16'h0122, 3'd1, 2'd3, seq_events(16'hD100));
        wait_idle("R4 code3");
        // R6: zero-count cluster keeps held value, still advances timestamp
        send(0, 16'h012A, 3'd0, 2'd0, seq_events(16'hE000));
        wait_idle("R6");
        send(0, 16'h0131, 3'd3, 2'd0, seq_events(16'hE100));
        wait_idle("R3 R5 partial");
        // R2: wrap of timestamp
        send(0, 16'hFFF7, 3'd4, 2'd0, seq_events(16'hF000));
        wait_idle("R2 pre");
        send(0, 16'h0003, 3'd5, 2'd0, seq_events(16'hF100));
        wait_idle("R2 wrap");
        // R1: new readout clears held and ignores distance
        send(1, 16'h4000, 3'd0, 2'd2, seq_events(16'h1111));
        wait_idle("R1 clear");
        send(0, 16'h4007, 3'd6, 2'd1, seq_events(16'h2200));
        wait_idle("R1 R3 after first");
        // long replay
        send(0, 16'h4007 + 16'd7 + 16'd300, 3'd7, 2'd2, seq_events(16'h3300));
        wait_idle("R4 long");

        // random clusters
        for (int n = 0; n < 60; n++) begin
            logic [15:0] ts;
            bit f;
            f  = ($urandom % 20) == 0;
            ts = m_exp + 16'($urandom % 6);
            send(f, ts, 3'($urandom % 8), 2'($urandom % 4), rand_events());
            if (n % 10 == 9) wait_idle("R7 random");
        end
        wait_idle("R5 R7 final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule